// File: doc/BRIEF.md
# Saturating PHY Error Event Counter

This block keeps an 8-bit statistics count of physical-layer error events and presents it as a 16-bit management register. Two counting modes are chosen by a mode input. In false-carrier mode every strobe on the event input adds one. In receive-error mode the event input marks invalid data symbols. The block tracks whole carrier events and adds at most one count for each event that contained an error. Any event that saw a collision adds nothing.

The count stops at its maximum value and does not roll over. A read strobe returns the current value and clears the count. When the count first reaches the midpoint of its range, the block sends a one-cycle pulse to the interrupt controller. A separate receive-error flag records that an error occurred. The same read strobe clears it. Symbol decoding and carrier detection are done upstream.

Top module: `phy_err_counter`

## Requirements
- R1: `rd_data_o[7:0]` always shows the current count and `rd_data_o[15:8]` is always 0.
- R2: The count saturates at 0xFF. Further qualifying events leave it at 0xFF.
- R3: `rd_data_o` shows the pre-clear value while `rd_i` is high. A read with no coinciding increment leaves the count at 0 on the following cycle.
- R4: An increment that falls in the same cycle as a read is applied after the clear, so the count becomes 1.
- R5: With `mode_i`=0 (false carrier), each clock cycle with `event_i` high adds one. `carrier_i` and `collision_i` have no effect in this mode.
- R6: With `mode_i`=1 (receive error), a carrier event is a run of cycles with `carrier_i` high. The count changes only at the first clock edge where `carrier_i` is sampled low after such a run. It rises by exactly one if `event_i` was high in at least one cycle of the run, however many error strobes occurred.
- R7: With `mode_i`=1, a carrier event in which `collision_i` was high in any cycle adds nothing, even if it contained error strobes.
- R8: With `mode_i`=1, `event_i` pulses while `carrier_i` is low add nothing.
- R9: `half_full_o` is high for exactly one cycle: the first cycle in which the count reads 0x80 after an increment from 0x7F. It is never high for any other value.
- R10: `err_latch_o` sets after any cycle with `mode_i`=1, `carrier_i` and `event_i` all high. A read clears it. A setting error in the same cycle as the read wins over the clear.
- R11: After reset, the count, `half_full_o` and `err_latch_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = false-carrier counting, 1 = receive-error counting |
| carrier_i | input | 1 | Valid carrier present (level) |
| event_i | input | 1 | Invalid-symbol strobe, or false-carrier strobe in mode 0 |
| collision_i | input | 1 | Collision present (level) |
| rd_i | input | 1 | Register read strobe; clears the count and the error flag |
| rd_data_o | output | 16 | Register read value; the count sits in the low byte |
| half_full_o | output | 1 | One-cycle pulse when the count reaches 0x80 |
| err_latch_o | output | 1 | Receive-error-seen flag |

## Verification
The bench drives the count past 0xFF. A wrapping counter would read a small value there instead of 0xFF. It reads exactly at the cycle where the 0x7F→0x80 step happens and checks that the half-full pulse lasts only one cycle. A level-style flag would stay high, and a detector on the value alone would fire again while the count sits at 0x80. It lines up a read with an increment. A design that clears after incrementing would read 0 there instead of 1.

In receive-error mode the bench sends several error strobes within one carrier event. A design that counts each strobe would overcount. It places a collision early in an event, away from the errors, so a design that checks the collision only at the end of the event would count it. It also sends strobes with no carrier present, and checks the error flag when a set and a read fall in the same cycle.

// File: rtl/phy_errcnt_pkg.sv
package phy_errcnt_pkg;
  typedef enum logic {
    CNT_FALSE_CARRIER = 1'b0,
    CNT_RX_ERROR      = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/errcnt_event_qual.sv
module errcnt_event_qual
  import phy_errcnt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cnt_mode_e mode_i,
  input  logic      carrier_i,
  input  logic      event_i,
  input  logic      collision_i,
  output logic      inc_o,
  output logic      rx_err_o
);
  logic in_evt_q, err_seen_q, col_seen_q;

  assign rx_err_o = (mode_i == CNT_RX_ERROR) && carrier_i && event_i;

  // carrier-event bookkeeping; flags are consumed when carrier drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_evt_q   <= 1'b0;
      err_seen_q <= 1'b0;
      col_seen_q <= 1'b0;
    end else if (carrier_i) begin
      in_evt_q   <= 1'b1;
      err_seen_q <= err_seen_q | event_i;
      col_seen_q <= col_seen_q | collision_i;
    end else begin
      in_evt_q   <= 1'b0;
      err_seen_q <= 1'b0;
      col_seen_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode_i)
      CNT_FALSE_CARRIER: inc_o = event_i;
      CNT_RX_ERROR:      inc_o = in_evt_q && !carrier_i && err_seen_q && !col_seen_q;
      default:           inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/errcnt_sat.sv
module errcnt_sat #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             half_o
);
  localparam logic [CNT_W-1:0] MAX_V     = '1;
  localparam logic [CNT_W-1:0] HALF_M1_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] ONE_V     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      half_q <= inc_i && !clr_i && (cnt_q == HALF_M1_V);
      if (clr_i)                        cnt_q <= inc_i ? ONE_V : '0;  // clear first, then count
      else if (inc_i && cnt_q != MAX_V) cnt_q <= cnt_q + ONE_V;
    end
  end

  assign cnt_o  = cnt_q;
  assign half_o = half_q;
endmodule

// File: rtl/errcnt_flag.sv
module errcnt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/phy_err_counter.sv
module phy_err_counter #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             carrier_i,
  input  logic             event_i,
  input  logic             collision_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             half_full_o,
  output logic             err_latch_o
);
  import phy_errcnt_pkg::*;

  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic             inc, rx_err;
  logic [CNT_W-1:0] cnt;

  errcnt_event_qual i_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (cnt_mode_e'(mode_i)),
    .carrier_i   (carrier_i),
    .event_i     (event_i),
    .collision_i (collision_i),
    .inc_o       (inc),
    .rx_err_o    (rx_err)
  );

  errcnt_sat #(.CNT_W(CNT_W)) i_sat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc),
    .clr_i  (rd_i),
    .cnt_o  (cnt),
    .half_o (half_full_o)
  );

  errcnt_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rx_err),
    .clr_i  (rd_i),
    .flag_o (err_latch_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o = {{PAD_W{1'b0}}, cnt};
    end else begin : g_nopad
      assign rd_data_o = cnt;
    end
  endgenerate
endmodule

// File: rtl/errcnt_checker.sv
module errcnt_checker #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             carrier_i,
  input logic             rd_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             half_full_o
);
  localparam logic [CNT_W-1:0] MAX_V  = '1;
  localparam logic [CNT_W-1:0] HALF_V = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  assign cnt = rd_data_o[CNT_W-1:0];

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:CNT_W] == '0);  // R1

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == MAX_V && !rd_i) |=> cnt == MAX_V);  // R2

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> cnt <= ONE_V);  // R3

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE_V));  // R5

  AST_RX_HOLD_IN_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && carrier_i && !rd_i) |=> $stable(cnt));  // R6

  AST_HALF_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_full_o |-> cnt == HALF_V);  // R9

  AST_HALF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_full_o |=> !half_full_o);  // R9
endmodule

bind phy_err_counter errcnt_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .carrier_i   (carrier_i),
  .rd_i        (rd_i),
  .rd_data_o   (rd_data_o),
  .half_full_o (half_full_o)
);

// File: tb/test_phy_err_counter.sv
module test_phy_err_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        carrier_i = 1'b0;
  logic        event_i = 1'b0;
  logic        collision_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        half_full_o;
  logic        err_latch_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  phy_err_counter i_phy_err_counter (
    .clk_i, .rst_ni, .mode_i, .carrier_i, .event_i, .collision_i,
    .rd_i, .rd_data_o, .half_full_o, .err_latch_o
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  // read value is checked before the strobe, then the strobe clears
  task automatic do_read(input string req, input logic [15:0] exp);
    chk(req, rd_data_o, exp);
    rd_i = 1'b1;
    step();
    rd_i = 1'b0;
  endtask

  task automatic carrier_evt(input int len, input int n_err_sym, input bit col);
    carrier_i = 1'b1;
    for (int i = 0; i < len; i++) begin
      event_i     = (i >= 1 && i <= n_err_sym);
      collision_i = col && (i == 0);
      step();
    end
    event_i = 1'b0; collision_i = 1'b0; carrier_i = 1'b0;
    step();
  endtask

  task automatic t_reset;
    chk("R11 count", rd_data_o, 16'h0000);
    chk("R11 half", {15'd0, half_full_o}, 16'h0);
    chk("R11 latch", {15'd0, err_latch_o}, 16'h0);
  endtask

  task automatic t_false_carrier;
    mode_i = 1'b0;
    carrier_i = 1'b1; collision_i = 1'b1;  // R5: ignored in this mode
    event_i = 1'b1; step(3);
    event_i = 1'b0; step(2);
    event_i = 1'b1; step();
    event_i = 1'b0; carrier_i = 1'b0; collision_i = 1'b0; step();
    chk("R5 fc count", rd_data_o, 16'h0004);
    chk("R10 no latch in fc mode", {15'd0, err_latch_o}, 16'h0);
    do_read("R3 read value", 16'h0004);
    chk("R3 cleared", rd_data_o, 16'h0000);
  endtask

  task automatic t_half_and_sat;
    mode_i = 1'b0;
    event_i = 1'b1; step(127);
    event_i = 1'b0;
    chk("R9 no pulse at 7f", {15'd0, half_full_o}, 16'h0);
    chk("R1 count 7f", rd_data_o, 16'h007F);
    event_i = 1'b1; step();
    event_i = 1'b0;
    chk("R9 pulse at 80", {15'd0, half_full_o}, 16'h1);
    chk("R9 value 80", rd_data_o, 16'h0080);
    step();
    chk("R9 pulse ends", {15'd0, half_full_o}, 16'h0);
    event_i = 1'b1; step(140);
    event_i = 1'b0;
    chk("R2 saturated", rd_data_o, 16'h00FF);
    chk("R1 upper zero", {rd_data_o[15:8], 8'h00}, 16'h0000);
    event_i = 1'b1; step(3); event_i = 1'b0;
    chk("R2 still ff", rd_data_o, 16'h00FF);
    chk("R9 no pulse at ff", {15'd0, half_full_o}, 16'h0);
    do_read("R3 read ff", 16'h00FF);
    chk("R3 cleared from ff", rd_data_o, 16'h0000);
  endtask

  task automatic t_read_collide;
    mode_i = 1'b0;
    event_i = 1'b1; step(2); event_i = 1'b0;
    chk("R4 before", rd_data_o, 16'h0002);
    event_i = 1'b1; rd_i = 1'b1; step();
    event_i = 1'b0; rd_i = 1'b0;
    chk("R4 inc after clear", rd_data_o, 16'h0001);
    do_read("R4 flush", 16'h0001);
  endtask

  task automatic t_rx_error;
    mode_i = 1'b1;
    carrier_i = 1'b1; event_i = 1'b1; step(2); event_i = 1'b0; step();
    chk("R6 held during carrier", rd_data_o, 16'h0000);
    carrier_i = 1'b0; step();
    chk("R6 one per event", rd_data_o, 16'h0001);
    carrier_evt(8, 5, 1'b0);
    chk("R6 multi errors one inc", rd_data_o, 16'h0002);
    carrier_evt(6, 0, 1'b0);
    chk("R6 clean event", rd_data_o, 16'h0002);
    carrier_evt(8, 3, 1'b1);
    chk("R7 collision suppresses", rd_data_o, 16'h0002);
    carrier_evt(5, 1, 1'b0);
    chk("R7 next event counts", rd_data_o, 16'h0003);
    carrier_i = 1'b0; event_i = 1'b1; step(4); event_i = 1'b0; step(2);
    chk("R8 no carrier ignored", rd_data_o, 16'h0003);
  endtask

  task automatic t_latch;
    mode_i = 1'b1;
    do_read("R3 rx read", 16'h0003);
    chk("R10 cleared by read", {15'd0, err_latch_o}, 16'h0);
    carrier_i = 1'b1; event_i = 1'b1; step();
    event_i = 1'b0;
    chk("R10 set", {15'd0, err_latch_o}, 16'h1);
    event_i = 1'b1; rd_i = 1'b1; step();
    event_i = 1'b0; rd_i = 1'b0;
    chk("R10 set wins", {15'd0, err_latch_o}, 16'h1);
    rd_i = 1'b1; step(); rd_i = 1'b0;
    chk("R10 clear", {15'd0, err_latch_o}, 16'h0);
    carrier_i = 1'b0; step();
  endtask

  initial begin
    step(2);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_false_carrier();
    t_half_and_sat();
    t_read_collide();
    t_rx_error();
    t_latch();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule